// File: doc/BRIEF.md
# Registered Integer ALU with Selective Overflow

This block is the execute-stage arithmetic and logic unit of a small RISC integer pipeline. It takes two 32-bit operands, a 5-bit shift distance and a 4-bit operation code. It returns a 32-bit result and an overflow flag. Both outputs are registered, so an operation presented in one cycle shows its result in the next.

The same adder serves two families of opcodes. The signed-checking family raises the overflow flag when the two's-complement result does not fit. The unsigned family returns the identical wrapped sum and never raises the flag. Immediate instruction forms use the same add paths: the decoder sign-extends the immediate outside this block and places it on the second operand.

The unit also provides bitwise AND, OR and NOR. NOR against zero gives bitwise NOT. It has three shifts and a signed set-less-than. The arithmetic right shift floors negative values, so it rounds toward minus infinity.

Top module: `int_alu`

## Requirements
- R1: Add with code 0 (signed) or code 1 (unsigned) returns the sum modulo 2^32; for example, 0xFFFFFFFF + 3 gives 2.
- R2: For code 0 (add) and code 2 (subtract a minus b), overflow is 1 exactly when the true signed result lies outside the 32-bit two's-complement range. For subtraction this is the case when the operand signs differ and the result sign differs from a.
- R3: Code 1 (add) and code 3 (subtract) return the wrapped result with overflow held at 0 for every pair of operands.
- R4: Code 7 shifts a left by the shift distance and fills the low bits with zeros; 0x00000002 shifted by 2 gives 0x00000008.
- R5: Code 8 shifts a right by the shift distance and fills the high bits with zeros.
- R6: Code 9 shifts a right and copies a's bit 31 into the vacated high bits; 0xFFFFFFE7 (-25) shifted by 4 gives 0xFFFFFFFE (-2).
- R7: Code 10 returns 1 in bit 0 when a is less than b as signed numbers and 0 otherwise. Bits 31 to 1 are zero. The answer stays correct when a minus b overflows.
- R8: Code 4 returns a AND b, code 5 returns a OR b, code 6 returns NOT(a OR b); code 6 with b equal to 0 gives NOT a.
- R9: Overflow is 0 for codes 1 and 3 through 15. Codes 11 to 15 return a result of 0.
- R10: The outputs show the operation presented at a rising clock edge from that edge on. While the active-low reset is low, result and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand or sign-extended immediate |
| shamt_i | input | 5 | Shift distance, 0 to 31 |
| result_o | output | 32 | Registered result |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The hardest case is set-less-than on operands whose difference overflows. A large negative a against a small positive b gives a subtraction result whose sign bit points the wrong way. The stimulus feeds 0x80000000 against 1 and 0x7FFFFFFF against 0x80000000, where the sign bit alone would give the wrong answer. The stimulus also sends operand pairs that overflow on the signed codes to the unsigned and logic codes. This shows that the flag stays low when the adder carries out of range but the opcode does not check for it.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD_S = 4'd0,
        OP_ADD_U = 4'd1,
        OP_SUB_S = 4'd2,
        OP_SUB_U = 4'd3,
        OP_AND   = 4'd4,
        OP_OR    = 4'd5,
        OP_NOR   = 4'd6,
        OP_SLL   = 4'd7,
        OP_SRL   = 4'd8,
        OP_SRA   = 4'd9,
        OP_SLT   = 4'd10,
        OP_RSV11 = 4'd11,
        OP_RSV12 = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } alu_op_e;

endpackage

// File: rtl/alu_addsub.sv
// Shared adder/subtractor: wrapped result, signed overflow and signed less-than.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         ovf_o,
    output logic         lt_o
);
    logic [W-1:0] b_eff;
    logic [W:0]   full;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
        sum_o = full[W-1:0];
        // operands of like sign producing a result of the other sign
        ovf_o = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
        // sign of the difference, corrected when it wrapped
        lt_o  = full[W-1] ^ ovf_o;
    end
endmodule

// File: rtl/alu_shifter.sv
// Log-depth barrel shifter; left shifts reuse the right chain on reversed bits.
module alu_shifter #(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   a_i,
    input  logic [SHW-1:0] shamt_i,
    input  logic           left_i,
    input  logic           arith_i,
    output logic [W-1:0]   res_o
);
    logic [W-1:0] a_rev;
    logic [W-1:0] chain_in;
    logic [W-1:0] chain_out_rev;
    logic         fill;
    logic [W-1:0] stg [0:SHW];

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_rev
            assign a_rev[gi]         = a_i[W-1-gi];
            assign chain_out_rev[gi] = stg[SHW][W-1-gi];
        end
    endgenerate

    assign fill     = arith_i & ~left_i & a_i[W-1];
    assign chain_in = left_i ? a_rev : a_i;
    assign stg[0]   = chain_in;

    genvar gk;
    generate
        for (gk = 0; gk < SHW; gk++) begin : g_stage
            localparam int D = 1 << gk;
            assign stg[gk+1] = shamt_i[gk] ? {{D{fill}}, stg[gk][W-1:D]} : stg[gk];
        end
    endgenerate

    assign res_o = left_i ? chain_out_rev : stg[SHW];
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND, OR and NOR in parallel.
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] nor_o
);
    always_comb begin
        and_o = a_i & b_i;
        or_o  = a_i | b_i;
        nor_o = ~(a_i | b_i);
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import int_alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 5,
    parameter int OPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   result_o,
    output logic           ovf_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         ovf;
    } out_t;

    alu_op_e      op;
    logic         sub_sel;
    logic [W-1:0] sum;
    logic         add_ovf;
    logic         lt;
    logic [W-1:0] sh_res;
    logic [W-1:0] and_r;
    logic [W-1:0] or_r;
    logic [W-1:0] nor_r;
    out_t         out_d;
    out_t         out_q;

    assign op      = alu_op_e'(op_i);
    assign sub_sel = (op == OP_SUB_S) || (op == OP_SUB_U) || (op == OP_SLT);

    alu_addsub #(.W(W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (sub_sel),
        .sum_o (sum),
        .ovf_o (add_ovf),
        .lt_o  (lt)
    );

    alu_shifter #(.W(W), .SHW(SHW)) u_shift (
        .a_i     (a_i),
        .shamt_i (shamt_i),
        .left_i  (op == OP_SLL),
        .arith_i (op == OP_SRA),
        .res_o   (sh_res)
    );

    alu_logic #(.W(W)) u_logic (
        .a_i   (a_i),
        .b_i   (b_i),
        .and_o (and_r),
        .or_o  (or_r),
        .nor_o (nor_r)
    );

    always_comb begin
        out_d = '0;
        case (op)
            OP_ADD_S, OP_SUB_S: begin
                out_d.res = sum;
                out_d.ovf = add_ovf;
            end
            OP_ADD_U, OP_SUB_U: out_d.res = sum;
            OP_AND:             out_d.res = and_r;
            OP_OR:              out_d.res = or_r;
            OP_NOR:             out_d.res = nor_r;
            OP_SLL, OP_SRL, OP_SRA: out_d.res = sh_res;
            OP_SLT:             out_d.res = {{(W-1){1'b0}}, lt};
            default:            out_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o = out_q.res;
    assign ovf_o    = out_q.ovf;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
    import int_alu_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 5,
    parameter int OPW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [OPW-1:0] op_i,
    input logic [W-1:0]   a_i,
    input logic [W-1:0]   b_i,
    input logic [SHW-1:0] shamt_i,
    input logic [W-1:0]   result_o,
    input logic           ovf_o
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R3: unsigned add/subtract never flag
    a_r3_unsigned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op_i) == OP_ADD_U || $past(op_i) == OP_SUB_U)) |-> !ovf_o);

    // R9: flag low for every opcode other than the signed-checking pair
    a_r9_nonarith_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) != OP_ADD_S && $past(op_i) != OP_SUB_S) |-> !ovf_o);

    // R2: signed add flag against operand and result signs
    a_r2_signed_add_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_ADD_S) |->
        (ovf_o == (($past(a_i[W-1]) == $past(b_i[W-1])) && (result_o[W-1] != $past(a_i[W-1])))));

    // R1: unsigned add wraps
    a_r1_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_ADD_U) |-> (result_o == $past(a_i) + $past(b_i)));

    // R4: shift by zero leaves the operand unchanged
    a_r4_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op_i) == OP_SLL || $past(op_i) == OP_SRL || $past(op_i) == OP_SRA)
         && $past(shamt_i) == '0) |-> (result_o == $past(a_i)));

    // R7: set-less-than upper bits zero
    a_r7_slt_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == OP_SLT) |-> (result_o[W-1:1] == '0));
endmodule

bind int_alu int_alu_chk #(.W(W), .SHW(SHW), .OPW(OPW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .shamt_i  (shamt_i),
    .result_o (result_o),
    .ovf_o    (ovf_o)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;
    logic        clk;
    logic        rst_n;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [4:0]  sh;
    logic [31:0] result;
    logic        ovf;

    int n_cmp;
    int n_bad;

    typedef struct {
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;
    exp_t sb[$];

    int_alu uut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_i(a), .b_i(b),
        .shamt_i(sh), .result_o(result), .ovf_o(ovf)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    function automatic exp_t model(input logic [3:0] o, input logic [31:0] x,
                                   input logic [31:0] y, input logic [4:0] s);
        exp_t e;
        e.res = '0;
        e.ovf = 1'b0;
        case (o)
            4'd0: begin e.res = x + y; e.ovf = (x[31] == y[31]) && (e.res[31] != x[31]); end
            4'd1: e.res = x + y;
            4'd2: begin e.res = x - y; e.ovf = (x[31] != y[31]) && (e.res[31] != x[31]); end
            4'd3: e.res = x - y;
            4'd4: e.res = x & y;
            4'd5: e.res = x | y;
            4'd6: e.res = ~(x | y);
            4'd7: e.res = x << s;
            4'd8: e.res = x >> s;
            4'd9: e.res = 32'($signed(x) >>> s);
            4'd10: e.res = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            default: e.res = '0;
        endcase
        return e;
    endfunction

    task automatic drive(input logic [3:0] o, input logic [31:0] x,
                         input logic [31:0] y, input logic [4:0] s, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; a = x; b = y; sh = s;
        e = model(o, x, y, s);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic expect_direct(input logic [31:0] r, input logic f, input string tag);
        n_cmp++;
        if (result !== r || ovf !== f) begin
            n_bad++;
            $display("FAIL %s: got res=%h ovf=%b, expected res=%h ovf=%b", tag, result, ovf, r, f);
        end
    endtask

    // monitor: one result per rising edge, sampled just after it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (result !== e.res || ovf !== e.ovf) begin
                    n_bad++;
                    $display("FAIL %s: got res=%h ovf=%b, expected res=%h ovf=%b",
                             e.tag, result, ovf, e.res, e.ovf);
                end
            end
        end
    end

    task automatic stimulus;
        rst_n = 1'b0;
        op = 4'd0; a = 32'h7FFF_FFFF; b = 32'd1; sh = '0;
        repeat (3) @(negedge clk);
        expect_direct(32'd0, 1'b0, "R10 reset clears outputs");
        rst_n = 1'b1;

        drive(4'd1, 32'hFFFF_FFFF, 32'd3, 5'd0, "R1 unsigned add wraps");
        drive(4'd0, 32'd5, 32'd7, 5'd0, "R1 signed add plain");
        drive(4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0, "R2 add positive overflow");
        drive(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R2 add negatives no overflow");
        drive(4'd0, 32'h8000_0000, 32'h8000_0000, 5'd0, "R2 add negative overflow");
        drive(4'd2, 32'h8000_0000, 32'd1, 5'd0, "R2 sub negative overflow");
        drive(4'd2, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0, "R2 sub positive overflow");
        drive(4'd2, 32'd10, 32'd3, 5'd0, "R2 sub plain");
        drive(4'd1, 32'h7FFF_FFFF, 32'd1, 5'd0, "R3 unsigned add silent");
        drive(4'd3, 32'h8000_0000, 32'd1, 5'd0, "R3 unsigned sub silent");
        drive(4'd3, 32'd0, 32'd1, 5'd0, "R3 unsigned sub wraps");
        drive(4'd7, 32'h0000_0002, 32'd0, 5'd2, "R4 sll by 2");
        drive(4'd7, 32'h8000_0001, 32'd0, 5'd31, "R4 sll by 31");
        drive(4'd7, 32'hDEAD_BEEF, 32'd0, 5'd0, "R4 sll by 0");
        drive(4'd8, 32'h8000_0000, 32'd0, 5'd4, "R5 srl zero fill");
        drive(4'd8, 32'hFFFF_FFFF, 32'd0, 5'd31, "R5 srl by 31");
        drive(4'd9, 32'hFFFF_FFE7, 32'd0, 5'd4, "R6 sra -25 by 4 floors");
        drive(4'd9, 32'h8000_0000, 32'd0, 5'd31, "R6 sra sign fill 31");
        drive(4'd9, 32'h4000_0000, 32'd0, 5'd30, "R6 sra positive");
        drive(4'd10, 32'hFFFF_FFFF, 32'd1, 5'd0, "R7 slt -1 < 1");
        drive(4'd10, 32'd1, 32'hFFFF_FFFF, 5'd0, "R7 slt 1 < -1 false");
        drive(4'd10, 32'h8000_0000, 32'd1, 5'd0, "R7 slt with overflowing difference");
        drive(4'd10, 32'h7FFF_FFFF, 32'h8000_0000, 5'd0, "R7 slt max vs min");
        drive(4'd10, 32'd42, 32'd42, 5'd0, "R7 slt equal");
        drive(4'd4, 32'hF0F0_1234, 32'hFF00_FF00, 5'd0, "R8 and");
        drive(4'd5, 32'hF0F0_1234, 32'h0F00_00FF, 5'd0, "R8 or");
        drive(4'd6, 32'hF0F0_1234, 32'h0F00_00FF, 5'd0, "R8 nor");
        drive(4'd6, 32'h1234_5678, 32'd0, 5'd0, "R8 nor with zero is not");
        drive(4'd4, 32'h7FFF_FFFF, 32'd1, 5'd0, "R9 logic op flag low");
        drive(4'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd1, "R9 shift flag low");
        drive(4'd15, 32'h7FFF_FFFF, 32'd1, 5'd3, "R9 unused code zero");
        drive(4'd11, 32'h8000_0000, 32'h8000_0000, 5'd0, "R9 unused code 11 zero");
        drive(4'd0, 32'h7FFF_FFFF, 32'd1, 5'd0, "R10 overflow before reset");
        repeat (3) @(negedge clk);

        rst_n = 1'b0;
        #1;
        expect_direct(32'd0, 1'b0, "R10 async reset clears");
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'd1, 32'd1, 32'd1, 5'd0, "R10 after reset");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        n_cmp = 0;
        n_bad = 0;
        fork
            stimulus();
            begin
                repeat (20000) @(posedge clk);
                n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule